// File: doc/BRIEF.md
# Predicate Define and Register Unit

This block keeps a small file of one-bit predicate registers and executes predicate-define operations against it. Every define slot compares two integer operands under a selectable condition. The slot is qualified by a guard predicate read from the file, and it may update up to two destination predicates. Each destination carries its own define type. Depending on that type, the guard value and the compare outcome, a destination receives a 1, receives a 0, or keeps its value.

Downstream pipeline stages use the read ports to fetch the guarding predicate of a guarded instruction. A 1 means the instruction commits normally. A 0 means it is nullified and may change no state. The unit takes several define slots in the same cycle. Set requests and clear requests aimed at the same register merge the way a wired OR or a wired AND would, and a fixed priority settles mixed requests. Decode has already produced the condition codes and define types before they reach the block.

Top module: `pred_define_unit`

## Requirements
- R1: A synchronous active-high reset clears predicates 1 to 15. After reset, every read port returns 0 for those indices and 1 for index 0.
- R2: Predicate 0 always reads 1. Any define aimed at index 0 leaves it at 1.
- R3: The condition code selects the compare: 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal. The signed flag (1 = two's complement) chooses the ordering for codes 2 to 5. Codes 6 and 7 produce a false result.
- R4: Type code 1 (unconditional) always writes its destination, with the compare result when the guard is 1 and with 0 when the guard is 0. Type code 2 (unconditional complement) writes the inverted result when the guard is 1 and writes 0 otherwise.
- R5: Type code 3 (or) writes 1 only when the guard is 1 and the result is 1. Type code 4 (or complement) writes 1 only when the guard is 1 and the result is 0. In every other case the destination is unchanged.
- R6: Type code 5 (and) writes 0 only when the guard is 1 and the result is 0. Type code 6 (and complement) writes 0 only when the guard is 1 and the result is 1. In every other case the destination is unchanged. Type codes 0 and 7 name no destination.
- R7: The guard value is read from the registered state at issue. A slot whose valid bit is 0 changes nothing.
- R8: When several set requests reach one register in a cycle, the outcome is their logical OR, and their order of issue does not matter.
- R9: When a register receives both a set request and a clear request in one cycle, and no unconditional write, it becomes 0.
- R10: When a register receives an unconditional write in a cycle, that write overrides any set or clear requests. Among several unconditional writes, the lowest position wins, where position = slot * 2 + destination number.
- R11: Read ports are combinational from registered state. A define issued in one cycle shows up on the read ports after the following rising edge.

Top module ports use packed arrays indexed by slot, then destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| def_valid | input | SLOTS | Per-slot define valid |
| def_src_a | input | SLOTS x DATA_W | First compare operand per slot |
| def_src_b | input | SLOTS x DATA_W | Second compare operand per slot |
| def_cond | input | SLOTS x 3 | Condition code per slot |
| def_signed | input | SLOTS | Signed compare flag per slot |
| def_guard | input | SLOTS x PIDX_W | Guard predicate index per slot |
| def_dst_idx | input | SLOTS x 2 x PIDX_W | Destination predicate indices |
| def_dst_type | input | SLOTS x 2 x 3 | Define type code per destination |
| rd_idx | input | RD_PORTS x PIDX_W | Read port predicate index |
| rd_val | output | RD_PORTS | Read port predicate value (commit when 1) |

## Verification
Directed patterns try each define type under all four guard and result combinations. This separates the types that always write from those that only set or only clear. Mixed-slot patterns aim set, clear and unconditional requests at one register, which exposes a wrong merge priority or a wrong slot ordering. Operands of -1 against 1 run under both signed-flag values and tell the signed ordering from the unsigned one. Random traffic with small operand ranges produces frequent equal compares and frequent index collisions, and a reference model scores it register by register after every cycle.

// File: rtl/pdu_pkg.sv
package pdu_pkg;

    localparam int unsigned COND_W  = 3;
    localparam int unsigned DTYPE_W = 3;
    localparam int unsigned DST_PER_SLOT = 2;

    typedef enum logic [COND_W-1:0] {
        CMP_EQ = 3'd0,
        CMP_NE = 3'd1,
        CMP_LT = 3'd2,
        CMP_LE = 3'd3,
        CMP_GT = 3'd4,
        CMP_GE = 3'd5
    } cmp_cond_e;

    typedef enum logic [DTYPE_W-1:0] {
        DT_NONE  = 3'd0,
        DT_UNC   = 3'd1,
        DT_UNC_N = 3'd2,
        DT_OR    = 3'd3,
        DT_OR_N  = 3'd4,
        DT_AND   = 3'd5,
        DT_AND_N = 3'd6
    } def_type_e;

    // Request one destination makes on the predicate file
    typedef struct packed {
        logic wr;   // unconditional write
        logic val;  // value for unconditional write
        logic set;  // wired-or set
        logic clr;  // wired-and clear
    } act_t;

    function automatic act_t pdu_action(def_type_e t, logic guard, logic res);
        act_t a;
        a = '0;
        case (t)
            DT_UNC: begin
                a.wr  = 1'b1;
                a.val = guard & res;
            end
            DT_UNC_N: begin
                a.wr  = 1'b1;
                a.val = guard & ~res;
            end
            DT_OR:    a.set = guard & res;
            DT_OR_N:  a.set = guard & ~res;
            DT_AND:   a.clr = guard & ~res;
            DT_AND_N: a.clr = guard & res;
            default:  a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/pdu_compare.sv
module pdu_compare
    import pdu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  cmp_cond_e         cond,
    input  logic              is_signed,
    output logic              result
);
    localparam int unsigned EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] ext_a;
    logic [EXT_W-1:0] ext_b;
    logic             eq;
    logic             lt;

    always_comb begin
        ext_a = {is_signed & src_a[DATA_W-1], src_a};
        ext_b = {is_signed & src_b[DATA_W-1], src_b};
        eq    = (src_a == src_b);
        lt    = ($signed(ext_a) < $signed(ext_b));
        case (cond)
            CMP_EQ:  result = eq;
            CMP_NE:  result = ~eq;
            CMP_LT:  result = lt;
            CMP_LE:  result = lt | eq;
            CMP_GT:  result = ~(lt | eq);
            CMP_GE:  result = ~lt;
            default: result = 1'b0;
        endcase
    end

endmodule

// File: rtl/pdu_define_slot.sv
module pdu_define_slot
    import pdu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                          valid,
    input  logic [DATA_W-1:0]             src_a,
    input  logic [DATA_W-1:0]             src_b,
    input  cmp_cond_e                     cond,
    input  logic                          is_signed,
    input  logic                          guard_val,
    input  def_type_e [DST_PER_SLOT-1:0]  dst_type,
    output act_t      [DST_PER_SLOT-1:0]  act
);
    logic cmp_res;

    pdu_compare #(.DATA_W(DATA_W)) u_cmp (
        .src_a     (src_a),
        .src_b     (src_b),
        .cond      (cond),
        .is_signed (is_signed),
        .result    (cmp_res)
    );

    for (genvar d = 0; d < DST_PER_SLOT; d++) begin : g_dst
        always_comb begin
            if (valid) act[d] = pdu_action(dst_type[d], guard_val, cmp_res);
            else       act[d] = '0;
        end
    end

endmodule

// File: rtl/pdu_pred_file.sv
module pdu_pred_file
    import pdu_pkg::*;
#(
    parameter int unsigned PRED_COUNT = 16,
    parameter int unsigned REQS       = 4,
    localparam int unsigned PIDX_W    = $clog2(PRED_COUNT)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  act_t [REQS-1:0]                req,
    input  logic [REQS-1:0][PIDX_W-1:0]    req_idx,
    output logic [PRED_COUNT-1:0]          pred_q
);
    logic [PRED_COUNT-1:1] state_q;

    assign pred_q = {state_q, 1'b1};

    for (genvar r = 1; r < PRED_COUNT; r++) begin : g_reg
        logic u_hit;
        logic u_val;
        logic any_set;
        logic any_clr;
        logic nxt;

        always_comb begin
            u_hit   = 1'b0;
            u_val   = 1'b0;
            any_set = 1'b0;
            any_clr = 1'b0;
            // descending walk: the lowest position's write is seen last and wins
            for (int k = REQS - 1; k >= 0; k--) begin
                if (req_idx[k] == PIDX_W'(r)) begin
                    if (req[k].wr) begin
                        u_hit = 1'b1;
                        u_val = req[k].val;
                    end
                    any_set = any_set | req[k].set;
                    any_clr = any_clr | req[k].clr;
                end
            end
            if (u_hit)        nxt = u_val;
            else if (any_clr) nxt = 1'b0;
            else if (any_set) nxt = 1'b1;
            else              nxt = state_q[r];
        end

        always_ff @(posedge clk) begin
            if (rst) state_q[r] <= 1'b0;
            else     state_q[r] <= nxt;
        end
    end

endmodule

// File: rtl/pred_define_unit.sv
module pred_define_unit
    import pdu_pkg::*;
#(
    parameter int unsigned PRED_COUNT = 16,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned SLOTS      = 2,
    parameter int unsigned RD_PORTS   = 2,
    localparam int unsigned PIDX_W    = $clog2(PRED_COUNT)
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic [SLOTS-1:0]                               def_valid,
    input  logic [SLOTS-1:0][DATA_W-1:0]                   def_src_a,
    input  logic [SLOTS-1:0][DATA_W-1:0]                   def_src_b,
    input  logic [SLOTS-1:0][COND_W-1:0]                   def_cond,
    input  logic [SLOTS-1:0]                               def_signed,
    input  logic [SLOTS-1:0][PIDX_W-1:0]                   def_guard,
    input  logic [SLOTS-1:0][DST_PER_SLOT-1:0][PIDX_W-1:0] def_dst_idx,
    input  logic [SLOTS-1:0][DST_PER_SLOT-1:0][DTYPE_W-1:0] def_dst_type,
    input  logic [RD_PORTS-1:0][PIDX_W-1:0]                rd_idx,
    output logic [RD_PORTS-1:0]                            rd_val
);
    localparam int unsigned REQS = SLOTS * DST_PER_SLOT;

    logic [PRED_COUNT-1:0]          pred_q;
    act_t [REQS-1:0]                req;
    logic [REQS-1:0][PIDX_W-1:0]    req_idx;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        def_type_e [DST_PER_SLOT-1:0] types;
        act_t      [DST_PER_SLOT-1:0] acts;

        for (genvar d = 0; d < DST_PER_SLOT; d++) begin : g_map
            assign types[d] = def_type_e'(def_dst_type[s][d]);
            assign req[s*DST_PER_SLOT + d]     = acts[d];
            assign req_idx[s*DST_PER_SLOT + d] = def_dst_idx[s][d];
        end

        pdu_define_slot #(.DATA_W(DATA_W)) u_slot (
            .valid     (def_valid[s]),
            .src_a     (def_src_a[s]),
            .src_b     (def_src_b[s]),
            .cond      (cmp_cond_e'(def_cond[s])),
            .is_signed (def_signed[s]),
            .guard_val (pred_q[def_guard[s]]),
            .dst_type  (types),
            .act       (acts)
        );
    end

    pdu_pred_file #(.PRED_COUNT(PRED_COUNT), .REQS(REQS)) u_file (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .req_idx (req_idx),
        .pred_q  (pred_q)
    );

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_val[p] = pred_q[rd_idx[p]];
    end

endmodule

// File: rtl/pdu_checker.sv
module pdu_checker
    import pdu_pkg::*;
#(
    parameter int unsigned PRED_COUNT = 16,
    parameter int unsigned SLOTS      = 2,
    localparam int unsigned PIDX_W    = $clog2(PRED_COUNT)
) (
    input logic                                            clk,
    input logic                                            rst,
    input logic [SLOTS-1:0]                                def_valid,
    input logic [SLOTS-1:0][PIDX_W-1:0]                    def_guard,
    input logic [SLOTS-1:0][DST_PER_SLOT-1:0][PIDX_W-1:0]  def_dst_idx,
    input logic [SLOTS-1:0][DST_PER_SLOT-1:0][DTYPE_W-1:0] def_dst_type,
    input logic [PRED_COUNT-1:0]                           pred_q
);
    logic only_or;
    logic only_and;

    always_comb begin
        only_or  = 1'b1;
        only_and = 1'b1;
        for (int s = 0; s < SLOTS; s++) begin
            for (int d = 0; d < DST_PER_SLOT; d++) begin
                if (def_valid[s]) begin
                    if (!(def_dst_type[s][d] inside {DT_NONE, DT_OR, DT_OR_N}))
                        only_or = 1'b0;
                    if (!(def_dst_type[s][d] inside {DT_NONE, DT_AND, DT_AND_N}))
                        only_and = 1'b0;
                end
            end
        end
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(|def_valid) |=> $stable(pred_q));

    // R5
    or_only_rise_chk: assert property (@(posedge clk) disable iff (rst)
        only_or |=> (($past(pred_q) & ~pred_q) == '0));

    // R6
    and_only_fall_chk: assert property (@(posedge clk) disable iff (rst)
        only_and |=> ((~$past(pred_q) & pred_q) == '0));

    // R4
    unc_false_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (def_valid[0] && def_dst_type[0][0] == DT_UNC && def_dst_idx[0][0] != '0
         && !pred_q[def_guard[0]])
        |=> !pred_q[$past(def_dst_idx[0][0])]);

endmodule

bind pred_define_unit pdu_checker #(.PRED_COUNT(PRED_COUNT), .SLOTS(SLOTS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .def_valid    (def_valid),
    .def_guard    (def_guard),
    .def_dst_idx  (def_dst_idx),
    .def_dst_type (def_dst_type),
    .pred_q       (pred_q)
);

// File: tb/pred_define_unit_tb.sv
module pred_define_unit_tb;
    localparam int NP = 16;
    localparam int DW = 32;
    localparam int NS = 2;
    localparam int NR = 2;
    localparam int IW = 4;

    logic                         clk = 1'b0;
    logic                         rst;
    logic [NS-1:0]                def_valid;
    logic [NS-1:0][DW-1:0]        def_src_a;
    logic [NS-1:0][DW-1:0]        def_src_b;
    logic [NS-1:0][2:0]           def_cond;
    logic [NS-1:0]                def_signed;
    logic [NS-1:0][IW-1:0]        def_guard;
    logic [NS-1:0][1:0][IW-1:0]   def_dst_idx;
    logic [NS-1:0][1:0][2:0]      def_dst_type;
    logic [NR-1:0][IW-1:0]        rd_idx;
    logic [NR-1:0]                rd_val;

    int n_cmp = 0;
    int n_bad = 0;
    logic [NP-1:0] mdl;

    always #10 clk = ~clk;   // 50 MHz

    pred_define_unit u_dut (
        .clk(clk), .rst(rst), .def_valid(def_valid), .def_src_a(def_src_a),
        .def_src_b(def_src_b), .def_cond(def_cond), .def_signed(def_signed),
        .def_guard(def_guard), .def_dst_idx(def_dst_idx), .def_dst_type(def_dst_type),
        .rd_idx(rd_idx), .rd_val(rd_val)
    );

    // R3 reference compare
    function automatic logic f_cmp(logic [DW-1:0] a, logic [DW-1:0] b, logic [2:0] c, logic sg);
        logic lt, eq;
        eq = (a == b);
        lt = sg ? ($signed(a) < $signed(b)) : (a < b);
        case (c)
            3'd0: return eq;
            3'd1: return !eq;
            3'd2: return lt;
            3'd3: return lt || eq;
            3'd4: return !(lt || eq);
            3'd5: return !lt;
            default: return 1'b0;
        endcase
    endfunction

    // Next model state from current inputs (R4-R10)
    function automatic logic [NP-1:0] f_next(logic [NP-1:0] cur);
        logic [NP-1:0] nx;
        nx = cur;
        for (int r = 1; r < NP; r++) begin
            logic uh, uv, st, cl;
            uh = 0; uv = 0; st = 0; cl = 0;
            for (int k = 2*NS-1; k >= 0; k--) begin
                int sl, d;
                logic g, res;
                sl = k / 2; d = k % 2;
                if (def_valid[sl] && def_dst_idx[sl][d] == IW'(r)) begin
                    g   = cur[def_guard[sl]];
                    res = f_cmp(def_src_a[sl], def_src_b[sl], def_cond[sl], def_signed[sl]);
                    case (def_dst_type[sl][d])
                        3'd1: begin uh = 1; uv = g && res;  end
                        3'd2: begin uh = 1; uv = g && !res; end
                        3'd3: if (g && res)  st = 1;
                        3'd4: if (g && !res) st = 1;
                        3'd5: if (g && !res) cl = 1;
                        3'd6: if (g && res)  cl = 1;
                        default: ;
                    endcase
                end
            end
            if (uh)      nx[r] = uv;
            else if (cl) nx[r] = 1'b0;
            else if (st) nx[r] = 1'b1;
        end
        nx[0] = 1'b1;
        return nx;
    endfunction

    task automatic check_all(string tag);
        for (int i = 0; i < NP; i += 2) begin
            rd_idx[0] = IW'(i);
            rd_idx[1] = IW'(i + 1);
            #1;
            for (int p = 0; p < NR; p++) begin
                n_cmp++;
                if (rd_val[p] !== mdl[i+p]) begin
                    n_bad++;
                    $display("FAIL %s pred%0d: got %0b expected %0b", tag, i+p, rd_val[p], mdl[i+p]);
                end
            end
        end
    endtask

    // inputs already driven; clock once, then check (R11: visible after the edge)
    task automatic step(string tag);
        logic [NP-1:0] nx;
        nx = rst ? {{(NP-1){1'b0}}, 1'b1} : f_next(mdl);
        @(posedge clk);
        @(negedge clk);
        mdl = nx;
        check_all(tag);
    endtask

    task automatic idle();
        def_valid = '0; def_src_a = '0; def_src_b = '0; def_cond = '0;
        def_signed = '0; def_guard = '0; def_dst_idx = '0; def_dst_type = '0;
    endtask

    task automatic op(int s, logic [DW-1:0] a, logic [DW-1:0] b, logic [2:0] c, logic sg,
                      logic [IW-1:0] g, logic [IW-1:0] d0, logic [2:0] t0,
                      logic [IW-1:0] d1, logic [2:0] t1);
        def_valid[s] = 1'b1; def_src_a[s] = a; def_src_b[s] = b; def_cond[s] = c;
        def_signed[s] = sg; def_guard[s] = g;
        def_dst_idx[s][0] = d0; def_dst_type[s][0] = t0;
        def_dst_idx[s][1] = d1; def_dst_type[s][1] = t1;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        mdl = '1;
        rd_idx = '0;
        idle();
        rst = 1'b1;
        @(negedge clk);
        step("R1 reset");
        rst = 1'b0;

        // R4 unconditional types, guard true
        idle(); op(0, 5, 5, 0, 0, 0, 3, 3'd1, 4, 3'd2); step("R4 unc eq");
        // R4 guard false (pred5 is 0): unc writes 0 to pred3
        idle(); op(0, 5, 5, 0, 0, 5, 3, 3'd1, 6, 3'd2); step("R4 unc guard0");
        // R5 or types, R8 merge across slots
        idle(); op(0, 1, 2, 0, 0, 0, 5, 3'd3, 6, 3'd4);
        op(1, 2, 2, 0, 0, 0, 5, 3'd3, 7, 3'd3); step("R5 R8 or merge");
        // R5 or with guard false leaves unchanged
        idle(); op(0, 2, 2, 0, 0, 3, 8, 3'd3, 9, 3'd4); step("R5 R7 or guard0");
        // R6 and types
        idle(); op(0, 1, 2, 0, 0, 0, 5, 3'd5, 6, 3'd6); step("R6 and");
        idle(); op(0, 1, 1, 0, 0, 0, 7, 3'd6, 4, 3'd5); step("R6 and comp");
        // R9 set and clear collide
        idle(); op(0, 3, 3, 0, 0, 0, 10, 3'd3, 11, 3'd3);
        op(1, 3, 4, 0, 0, 0, 10, 3'd5, 11, 3'd0); step("R9 clear wins");
        // R10 unconditional beats clear; lowest position among unc
        idle(); op(0, 3, 4, 0, 0, 0, 12, 3'd5, 13, 3'd2);
        op(1, 3, 3, 0, 0, 0, 12, 3'd1, 13, 3'd1); step("R10 unc priority");
        idle(); op(0, 3, 4, 0, 0, 0, 14, 3'd1, 14, 3'd2); step("R10 same slot");
        // R2 writes to index 0 ignored
        idle(); op(0, 3, 4, 0, 0, 0, 0, 3'd1, 0, 3'd5); step("R2 pred0");
        // R7 invalid slot does nothing
        idle(); op(1, 3, 4, 0, 0, 0, 12, 3'd1, 13, 3'd2); def_valid[1] = 1'b0;
        step("R7 invalid");
        // R3 signed vs unsigned, undefined codes
        idle(); op(0, 32'hFFFF_FFFF, 1, 3'd2, 1, 0, 1, 3'd1, 2, 3'd1);
        op(1, 32'hFFFF_FFFF, 1, 3'd2, 0, 0, 3, 3'd1, 4, 3'd1); step("R3 lt signed");
        idle(); op(0, 32'h8000_0000, 7, 3'd5, 1, 0, 1, 3'd1, 2, 3'd1);
        op(1, 7, 7, 3'd6, 0, 0, 3, 3'd2, 4, 3'd1); step("R3 ge/undef");
        idle(); op(0, 9, 7, 3'd4, 0, 0, 5, 3'd1, 6, 3'd1);
        op(1, 7, 7, 3'd3, 1, 0, 7, 3'd1, 8, 3'd1); step("R3 gt/le");
        idle(); step("R11 idle hold");

        for (int it = 0; it < 600; it++) begin
            idle();
            for (int s = 0; s < NS; s++) begin
                def_valid[s] = ($urandom % 8) != 0;
                def_src_a[s] = ($urandom % 5 == 0) ? $urandom : DW'($urandom % 3) - 1;
                def_src_b[s] = ($urandom % 5 == 0) ? $urandom : DW'($urandom % 3) - 1;
                def_cond[s]  = 3'($urandom);
                def_signed[s] = 1'($urandom);
                def_guard[s] = ($urandom % 2) ? '0 : IW'($urandom);
                for (int d = 0; d < 2; d++) begin
                    def_dst_idx[s][d]  = IW'($urandom % 6);
                    def_dst_type[s][d] = 3'($urandom);
                end
            end
            step("R4 R5 R6 R8 R9 R10 random");
            if (it == 300) begin
                idle(); rst = 1'b1; step("R1 mid reset"); rst = 1'b0;
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule